// File: doc/BRIEF.md
# Ethernet Transmit Framer with Padding

This block turns frames offered by a user transmit queue into a byte-wide transmit stream for a media-independent interface. The queue side presents one byte at a time with a valid flag and an end-of-frame flag. The block accepts a byte only when its ready output is high. For each frame the block first sends the preamble and the start frame delimiter. It then forwards the user bytes and fills short frames with zero bytes up to the 60-byte minimum. After that it appends a CRC-32 frame check sequence, which is updated eight bits per clock. Finally it holds the transmit enable low for the interframe gap before the next frame may start.

A second lane width is chosen with `nibble_mode`. In that mode every byte takes two clocks on `txd[3:0]`, low nibble first, and the upper four lines are held at zero. A free-running phase toggle paces all framing in this mode, so a frame always spans an even number of nibble clocks.

The queue is expected to work in store-and-forward fashion. Once a frame has begun, its bytes are valid whenever ready is high, up to and including the byte flagged last. `nibble_mode` is changed only while the line is idle.

Top module: `eth_tx_framer`

## Requirements
- R1: During reset and in the first cycle after it, `tx_en` is 0 and `s_ready` is 0.
- R2: Each frame on the line begins with seven bytes of 0x55 and then one byte of 0xD5. `tx_en` rises on the first of these bytes.
- R3: A frame with 60 to 1514 user bytes carries those bytes unchanged and in order, directly after 0xD5, with no pad bytes added.
- R4: A frame with 1 to 59 user bytes carries those bytes unchanged, followed by 0x00 bytes until the data field is exactly 60 bytes long.
- R5: Directly after the data field come four check bytes, least significant byte first. They are the bitwise complement of a CRC-32 over the data field (padding included, preamble and delimiter excluded), using reflected polynomial 0xEDB88320 and a start value of 0xFFFFFFFF.
- R6: Between two frames `tx_en` stays low for at least 12 byte times. When the next frame is already offered as the previous one ends, the gap is exactly 12 byte times, which is 12 clocks in byte mode and 24 clocks in nibble mode.
- R7: With `nibble_mode`=1, each byte is sent as two clocks on `txd[3:0]`, bits 3:0 first, with `txd[7:4]`=0. The number of clocks with `tx_en` high in a frame is even.
- R8: `s_ready` is high only while user bytes are being placed on the line, once per byte time. A frame of N bytes offered without stalls is taken with its first and last bytes (N-1) clocks apart in byte mode and 2(N-1) clocks apart in nibble mode.
- R9: Within a frame, `tx_en` stays high without a break from the first preamble byte to the last check byte. The frame spans 8 + max(N,60) + 4 byte times, and exactly one line frame is produced per offered frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nibble_mode | input | 1 | 1: four-bit lane, two clocks per byte; 0: eight-bit lane |
| s_data | input | 8 | User byte from the transmit queue |
| s_valid | input | 1 | `s_data` holds a byte |
| s_last | input | 1 | The current byte ends its frame |
| s_ready | output | 1 | The byte on `s_data` is taken at this clock edge |
| txd | output | 8 | Line data (bits 3:0 only in nibble mode) |
| tx_en | output | 1 | Line data valid |

## Verification
Each line byte is registered once in the sequencer. When the queue offers a frame to an idle block in byte mode, the first 0x55 therefore appears one clock after the edge that sees `s_valid`, and every later byte follows one clock after the byte before it. In nibble mode each byte is held for two clocks, and the edges that advance the framing come every second clock. The bench drives inputs on falling edges and samples the line on falling edges. It rebuilds each frame byte by byte, or from nibble pairs, and compares it position by position with an expected image built from the requirements. Gaps are counted in sampled low clocks and ready timing in clocks between accepted bytes, so none of the checks depends on ordering at a rising edge.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SFD,
        ST_DATA,
        ST_PAD,
        ST_FCS,
        ST_GAP
    } tx_state_e;

    localparam logic [7:0]  PRE_BYTE   = 8'h55;
    localparam logic [7:0]  SFD_BYTE   = 8'hD5;
    localparam logic [7:0]  PAD_BYTE   = 8'h00;
    localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED   = 32'hFFFF_FFFF;
    localparam int          FCS_BYTES  = 4;

    // one shift of the reflected CRC-32 register with one input bit
    function automatic logic [31:0] crc_bit(logic [31:0] c, logic b);
        logic fb;
        fb = c[0] ^ b;
        return fb ? ((c >> 1) ^ CRC_POLY_R) : (c >> 1);
    endfunction

    // eight single-bit steps unrolled into one clock, bit 0 first
    function automatic logic [31:0] crc_byte(logic [31:0] c, logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int k = 0; k < 8; k++) begin
            r = crc_bit(r, d[k]);
        end
        return r;
    endfunction

    function automatic logic [7:0] fcs_byte(logic [31:0] c, logic [1:0] idx);
        logic [31:0] inv;
        inv = ~c;
        return inv[8*idx +: 8];
    endfunction

endpackage

// File: rtl/eth_tx_crc.sv
module eth_tx_crc
    import eth_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        init,
    input  logic        en,
    input  logic [7:0]  data,
    output logic [31:0] crc_q
);

    always_ff @(posedge clk) begin
        if (rst || init) begin
            crc_q <= CRC_SEED;
        end else if (en) begin
            crc_q <= crc_byte(crc_q, data);
        end
    end

endmodule

// File: rtl/eth_tx_nibbler.sv
module eth_tx_nibbler (
    input  logic       clk,
    input  logic       rst,
    input  logic       nibble_mode,
    input  logic [7:0] cur_byte,
    input  logic       cur_en,
    output logic       byte_adv,
    output logic [7:0] txd,
    output logic       tx_en
);

    logic phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= 1'b0;
        end else begin
            phase <= nibble_mode ? ~phase : 1'b0;
        end
    end

    // in nibble mode a new byte is loaded only after its high half was shown
    assign byte_adv = !nibble_mode || phase;
    assign tx_en    = cur_en;

    always_comb begin
        if (nibble_mode) begin
            txd = {4'h0, phase ? cur_byte[7:4] : cur_byte[3:0]};
        end else begin
            txd = cur_byte;
        end
    end

endmodule

// File: rtl/eth_tx_seq.sv
module eth_tx_seq
    import eth_tx_pkg::*;
#(
    parameter int LEN_W    = 16,
    parameter int PRE_LEN  = 7,
    parameter int MIN_DATA = 60,
    parameter int GAP_LEN  = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        byte_adv,
    input  logic [7:0]  s_data,
    input  logic        s_valid,
    input  logic        s_last,
    input  logic [31:0] crc_q,
    output logic        s_ready,
    output logic        crc_init,
    output logic        crc_en,
    output logic [7:0]  crc_data,
    output logic [7:0]  out_byte,
    output logic        out_en
);

    localparam int CNT_MAX = (PRE_LEN > GAP_LEN) ? PRE_LEN : GAP_LEN;
    localparam int CNT_W   = (CNT_MAX < 4) ? 2 : $clog2(CNT_MAX + 1);
    localparam logic [LEN_W-1:0] MIN_L   = LEN_W'(MIN_DATA);
    localparam logic [CNT_W-1:0] PRE_END = CNT_W'(PRE_LEN - 1);
    localparam logic [CNT_W-1:0] GAP_END = CNT_W'(GAP_LEN - 1);
    localparam logic [CNT_W-1:0] FCS_END = CNT_W'(FCS_BYTES - 1);

    typedef struct packed {
        tx_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [LEN_W-1:0] len;
        logic [7:0]       dat;
        logic             en;
    } seq_t;

    seq_t q, nx;
    logic [LEN_W-1:0] len_inc;

    assign len_inc = q.len + 1'b1;

    always_comb begin
        nx = q;
        if (byte_adv) begin
            unique case (q.st)
                ST_IDLE: begin
                    nx.en  = 1'b0;
                    nx.dat = PAD_BYTE;
                    if (s_valid) begin
                        nx.st  = ST_PRE;
                        nx.en  = 1'b1;
                        nx.dat = PRE_BYTE;
                        nx.cnt = CNT_W'(1);
                    end
                end
                ST_PRE: begin
                    nx.dat = PRE_BYTE;
                    nx.cnt = q.cnt + 1'b1;
                    if (q.cnt == PRE_END) nx.st = ST_SFD;
                end
                ST_SFD: begin
                    nx.dat = SFD_BYTE;
                    nx.len = '0;
                    nx.st  = ST_DATA;
                end
                ST_DATA: begin
                    if (s_valid) begin
                        nx.dat = s_data;
                        nx.len = len_inc;
                        nx.cnt = '0;
                        if (s_last) nx.st = (len_inc < MIN_L) ? ST_PAD : ST_FCS;
                    end
                end
                ST_PAD: begin
                    nx.dat = PAD_BYTE;
                    nx.len = len_inc;
                    nx.cnt = '0;
                    if (len_inc == MIN_L) nx.st = ST_FCS;
                end
                ST_FCS: begin
                    nx.dat = fcs_byte(crc_q, q.cnt[1:0]);
                    nx.cnt = q.cnt + 1'b1;
                    if (q.cnt == FCS_END) begin
                        nx.st  = ST_GAP;
                        nx.cnt = '0;
                    end
                end
                ST_GAP: begin
                    nx.en  = 1'b0;
                    nx.dat = PAD_BYTE;
                    nx.cnt = q.cnt + 1'b1;
                    if (q.cnt == GAP_END) nx.st = ST_IDLE;
                end
                default: nx.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{st: ST_IDLE, cnt: '0, len: '0, dat: '0, en: 1'b0};
        end else begin
            q <= nx;
        end
    end

    assign s_ready  = byte_adv && (q.st == ST_DATA);
    assign crc_init = byte_adv && (q.st == ST_SFD);
    assign crc_en   = byte_adv && (((q.st == ST_DATA) && s_valid) || (q.st == ST_PAD));
    assign crc_data = (q.st == ST_PAD) ? PAD_BYTE : s_data;
    assign out_byte = q.dat;
    assign out_en   = q.en;

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer #(
    parameter int LEN_W    = 16,
    parameter int PRE_LEN  = 7,
    parameter int MIN_DATA = 60,
    parameter int GAP_LEN  = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       nibble_mode,
    input  logic [7:0] s_data,
    input  logic       s_valid,
    input  logic       s_last,
    output logic       s_ready,
    output logic [7:0] txd,
    output logic       tx_en
);

    logic        byte_adv;
    logic        crc_init, crc_en;
    logic [7:0]  crc_data;
    logic [31:0] crc_q;
    logic [7:0]  cur_byte;
    logic        cur_en;

    eth_tx_seq #(
        .LEN_W(LEN_W), .PRE_LEN(PRE_LEN), .MIN_DATA(MIN_DATA), .GAP_LEN(GAP_LEN)
    ) u_seq (
        .clk(clk), .rst(rst), .byte_adv(byte_adv),
        .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .crc_q(crc_q),
        .s_ready(s_ready), .crc_init(crc_init), .crc_en(crc_en), .crc_data(crc_data),
        .out_byte(cur_byte), .out_en(cur_en)
    );

    eth_tx_crc u_crc (
        .clk(clk), .rst(rst), .init(crc_init), .en(crc_en),
        .data(crc_data), .crc_q(crc_q)
    );

    eth_tx_nibbler u_nib (
        .clk(clk), .rst(rst), .nibble_mode(nibble_mode),
        .cur_byte(cur_byte), .cur_en(cur_en),
        .byte_adv(byte_adv), .txd(txd), .tx_en(tx_en)
    );

endmodule

// File: rtl/eth_tx_framer_chk.sv
module eth_tx_framer_chk #(
    parameter int MIN_LINE_BYTES = 72,
    parameter int GAP_BYTES      = 12
) (
    input logic       clk,
    input logic       rst,
    input logic       nibble_mode,
    input logic       s_ready,
    input logic [7:0] txd,
    input logic       tx_en
);

    logic [15:0] run_cnt;
    logic [15:0] gap_cnt;
    logic        seen_end;
    logic [15:0] mult;

    assign mult = nibble_mode ? 16'd2 : 16'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt  <= '0;
            gap_cnt  <= '0;
            seen_end <= 1'b0;
        end else begin
            if (tx_en) begin
                if (run_cnt != 16'hFFFF) run_cnt <= run_cnt + 1'b1;
                gap_cnt <= '0;
            end else begin
                run_cnt <= '0;
                if (gap_cnt != 16'hFFFF) gap_cnt <= gap_cnt + 1'b1;
                if (run_cnt != '0) seen_end <= 1'b1;
            end
        end
    end

    // R1: line is quiet right after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) $past(rst) |-> (!tx_en && !s_ready));

    // R2: first byte of a frame in byte mode is a preamble byte
    a_r2_first_preamble: assert property (@(posedge clk) disable iff (rst)
        (!nibble_mode && $rose(tx_en)) |-> (txd == 8'h55));

    // R6: at least the gap between frames
    a_r6_min_gap: assert property (@(posedge clk) disable iff (rst)
        ($rose(tx_en) && seen_end) |-> (gap_cnt >= 16'(GAP_BYTES) * mult));

    // R7: upper lane idle in nibble mode
    a_r7_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (nibble_mode && tx_en) |-> (txd[7:4] == 4'h0));

    // R7: frame never ends after an odd nibble
    a_r7_whole_bytes: assert property (@(posedge clk) disable iff (rst)
        (nibble_mode && $fell(tx_en)) |-> !run_cnt[0]);

    // R8: one byte per two clocks in nibble mode, and only while sending
    a_r8_ready_pace: assert property (@(posedge clk) disable iff (rst)
        (nibble_mode && s_ready) |=> !s_ready);
    a_r8_ready_in_frame: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> tx_en);

    // R9: no line frame shorter than the padded minimum
    a_r9_min_length: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_en) |-> (run_cnt >= 16'(MIN_LINE_BYTES) * mult));

endmodule

bind eth_tx_framer eth_tx_framer_chk u_chk (
    .clk(clk), .rst(rst), .nibble_mode(nibble_mode),
    .s_ready(s_ready), .txd(txd), .tx_en(tx_en)
);

// File: tb/eth_tx_framer_tb.sv
module eth_tx_framer_tb;

    localparam int NF  = 14;
    localparam int MEM = 4096;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       nibble_mode = 1'b0;
    logic [7:0] s_data = 8'h00;
    logic       s_valid = 1'b0;
    logic       s_last = 1'b0;
    logic       s_ready;
    logic [7:0] txd;
    logic       tx_en;

    always #10 clk = ~clk;

    eth_tx_framer u_dut (
        .clk(clk), .rst(rst), .nibble_mode(nibble_mode),
        .s_data(s_data), .s_valid(s_valid), .s_last(s_last),
        .s_ready(s_ready), .txd(txd), .tx_en(tx_en)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    logic [7:0]  pay [0:MEM-1];
    int          f_off [NF];
    int          f_len [NF];
    int          f_dly [NF];
    logic [31:0] f_fcs [NF];

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int body_len(int f);
        return (f_len[f] < 60) ? 60 : f_len[f];
    endfunction

    function automatic logic [31:0] ref_fcs(int f);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < body_len(f); i++) begin
            logic [7:0] b;
            b = (i < f_len[f]) ? pay[f_off[f] + i] : 8'h00;
            c = c ^ {24'h0, b};
            for (int k = 0; k < 8; k++) begin
                c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
            end
        end
        return ~c;
    endfunction

    function automatic logic [7:0] exp_byte(int f, int i);
        int body;
        body = body_len(f);
        if (i < 7) return 8'h55;
        if (i == 7) return 8'hD5;
        if (i < 8 + f_len[f]) return pay[f_off[f] + i - 8];
        if (i < 8 + body) return 8'h00;
        if (i < 12 + body) return f_fcs[f][8*(i-8-body) +: 8];
        return 8'hXX;
    endfunction

    // ---------------- line monitor ----------------
    int   mon_f = 0, idx = 0, nib_cnt = 0, gap = 0;
    int   pre_err = 0, body_err = 0, fcs_err = 0, up_err = 0;
    bit   in_fr = 0, have_prev = 0, half = 0, last_mode = 0;
    logic [3:0] lo_nib;

    task automatic take_byte(logic [7:0] b);
        if (mon_f < NF) begin
            if (b !== exp_byte(mon_f, idx)) begin
                if (idx < 8) pre_err++;
                else if (idx < 8 + body_len(mon_f)) body_err++;
                else fcs_err++;
            end
        end
        idx++;
    endtask

    always @(negedge clk) begin
        if (rst) begin
            in_fr = 0; have_prev = 0; gap = 0;
        end else begin
            if (nibble_mode != last_mode) have_prev = 0;
            last_mode = nibble_mode;
            if (tx_en) begin
                if (!in_fr) begin
                    if (have_prev && mon_f < NF) begin
                        check(gap >= 12 * (nibble_mode ? 2 : 1), "R6", "min gap clocks",
                              gap, 12 * (nibble_mode ? 2 : 1));
                        if (f_dly[mon_f] == 0)
                            check(gap == 12 * (nibble_mode ? 2 : 1), "R6", "back-to-back gap clocks",
                                  gap, 12 * (nibble_mode ? 2 : 1));
                    end
                    in_fr = 1; idx = 0; nib_cnt = 0; half = 0;
                    pre_err = 0; body_err = 0; fcs_err = 0; up_err = 0;
                end
                if (nibble_mode) begin
                    nib_cnt++;
                    if (txd[7:4] != 4'h0) up_err++;
                    if (!half) begin
                        lo_nib = txd[3:0];
                        half = 1;
                    end else begin
                        take_byte({txd[3:0], lo_nib});
                        half = 0;
                    end
                end else begin
                    take_byte(txd);
                end
            end else begin
                if (in_fr) begin
                    if (mon_f < NF) begin
                        check(idx == 12 + body_len(mon_f), "R9", "line frame bytes",
                              idx, 12 + body_len(mon_f));
                        check(pre_err == 0, "R2", "preamble/SFD byte errors", pre_err, 0);
                        if (f_len[mon_f] < 60)
                            check(body_err == 0, "R4", "padded data field byte errors", body_err, 0);
                        else
                            check(body_err == 0, "R3", "data field byte errors", body_err, 0);
                        check(fcs_err == 0, "R5", "check byte errors", fcs_err, 0);
                        if (nibble_mode) begin
                            check(nib_cnt % 2 == 0, "R7", "nibble clocks parity", nib_cnt % 2, 0);
                            check(up_err == 0, "R7", "upper lane nonzero clocks", up_err, 0);
                        end
                    end else begin
                        check(0, "R9", "unexpected extra frame index", mon_f, NF - 1);
                    end
                    mon_f++;
                    in_fr = 0;
                    have_prev = 1;
                    gap = 0;
                end
                gap++;
            end
        end
    end

    // ---------------- driver ----------------
    task automatic send(int f);
        int c0;
        c0 = 0;
        for (int i = 0; i < f_len[f]; i++) begin
            s_data  = pay[f_off[f] + i];
            s_valid = 1'b1;
            s_last  = (i == f_len[f] - 1);
            while (!s_ready) @(negedge clk);
            if (i == 0) c0 = cyc;
            if (i == f_len[f] - 1)
                check(cyc - c0 == (f_len[f] - 1) * (nibble_mode ? 2 : 1), "R8",
                      "clocks from first to last accepted byte",
                      cyc - c0, (f_len[f] - 1) * (nibble_mode ? 2 : 1));
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL R9 watchdog: actual %0d frames expected %0d", mon_f, NF);
            summary();
            $finish;
        end
    end

    initial begin
        int lens [NF];
        int dlys [NF];
        int off;
        int seed;
        seed = $urandom(32'h5EED_0042);
        lens = '{1, 59, 60, 1514, 61, 0, 0, 0, 1, 60, 59, 0, 0, 0};
        dlys = '{0, 0, 0, 0, 5, 0, 0, 0, 0, 0, 0, 0, 7, 0};
        off = 0;
        for (int f = 0; f < NF; f++) begin
            f_len[f] = (lens[f] == 0) ? (1 + int'($urandom % 120)) : lens[f];
            f_dly[f] = dlys[f];
            if (f == 6) f_dly[f] = 1 + int'($urandom % 30);
            f_off[f] = off;
            for (int i = 0; i < f_len[f]; i++) pay[off + i] = 8'($urandom);
            off += f_len[f];
            f_fcs[f] = ref_fcs(f);
        end

        repeat (4) @(negedge clk);
        check(tx_en == 1'b0, "R1", "tx_en during reset", tx_en, 0);
        check(s_ready == 1'b0, "R1", "s_ready during reset", s_ready, 0);
        rst = 1'b0;
        @(negedge clk);
        check(tx_en == 1'b0, "R1", "tx_en after reset", tx_en, 0);
        check(s_ready == 1'b0, "R1", "s_ready after reset", s_ready, 0);

        // byte lane
        for (int f = 0; f < 8; f++) begin
            if (f_dly[f] > 0) begin
                s_valid = 1'b0;
                repeat (f_dly[f]) @(negedge clk);
            end
            send(f);
        end
        s_valid = 1'b0;
        s_last  = 1'b0;
        while (mon_f < 8) @(negedge clk);
        repeat (30) @(negedge clk);

        // nibble lane
        nibble_mode = 1'b1;
        repeat (3) @(negedge clk);
        for (int f = 8; f < NF; f++) begin
            if (f_dly[f] > 0) begin
                s_valid = 1'b0;
                repeat (f_dly[f]) @(negedge clk);
            end
            send(f);
        end
        s_valid = 1'b0;
        s_last  = 1'b0;
        while (mon_f < NF) @(negedge clk);
        repeat (200) @(negedge clk);
        check(mon_f == NF, "R9", "frames seen on line", mon_f, NF);
        check(tx_en == 1'b0, "R9", "line idle at end", tx_en, 0);
        summary();
        $finish;
    end

endmodule